// File: doc/BRIEF.md
# Multidrop wake-up UART channel

This block is one asynchronous serial channel, with a transmitter and a receiver, for a multidrop network where each character carries a ninth tag bit. The tag marks the character as an address (1) or as data (0). A master station sends an address character and then data characters. Each listening station keeps its receiver disabled until its CPU has seen an address that matches its own. The CPU then enables the receiver for the data that follows.

The block is driven by a bit-rate tick at sixteen times the baud rate, which comes from outside. It also takes a small set of mode inputs and a transmit holding-register write. It drives the serial output line and samples the serial input line. Each character the receiver accepts is presented for one cycle as a push toward an external receive FIFO. The push carries the data bits, the received tag, a framing-error flag and a break flag. The same cycle raises a ready pulse that wakes the CPU.

The receiver always tracks the line, whether or not it is enabled. The enable only decides which completed characters are pushed.

Top module: `mdrop_uart_chan`

## Requirements
- R1: After reset, `txd` is high, `thr_empty` is high, and no push, ready or overrun pulse appears while the receive line stays idle.
- R2: A transmitted character is a low start bit, then 5 to 8 data bits sent LSB first (`cfg_dsel` 2'b00=5, 01=6, 10=7, 11=8), then its remaining bits. Every bit lasts 16 ticks of `tick16`.
- R3: When `cfg_pmode` equals 2'b11 (multidrop), one tag bit follows the data bits. The tag bit equals the `cfg_adtag` value captured when the character moves from the holding register to the shift register. In any other mode, no tag bit is sent.
- R4: The frame ends with one stop bit (high), or with two when `cfg_stop2` is 1. A character waiting in the holding register starts on the first tick after the last stop bit ends.
- R5: A low level on `rxd` is taken as a start bit only if it is still low at the 8th tick after detection. If the line is high there, the receiver returns to idle and pushes nothing.
- R6: When `rx_en` is 1, every completed character is pushed once. `fifo_data` holds the data bits with unused upper bits zero. In multidrop mode, `fifo_adtag` holds the received tag bit; in other modes it is 0.
- R7: When `rx_en` is 0 in multidrop mode, a character with tag 1 is pushed and pulses `rx_ready`, and a character with tag 0 is discarded with no pulse.
- R8: When `rx_en` is 0 outside multidrop mode, no ordinary character is pushed.
- R9: If the first stop bit is sampled low, the pushed character has `fifo_ferr` set. This holds whether the receiver is enabled or disabled.
- R10: If every data bit, the tag bit (when present) and the stop bit are all received as zero, the character is pushed with `fifo_brk` and `fifo_ferr` set, even when the receiver is disabled. No new start bit is recognised until the line has been seen high.
- R11: A character that would be pushed while `fifo_full` is 1 is not pushed and pulses `rx_ovr` instead. A discarded character never causes an overrun.
- R12: `thr_empty` goes low on the cycle after a `thr_wr`, and goes high again when the held character is loaded, in the same cycle as its start bit appears on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_pmode | input | 2 | Parity/tag mode; 2'b11 selects multidrop |
| cfg_adtag | input | 1 | Tag to transmit: 1 address, 0 data |
| cfg_dsel | input | 2 | Data bits per character, 5 + value |
| cfg_stop2 | input | 1 | 1 selects two stop bits on transmit |
| rx_en | input | 1 | Receiver enable |
| thr_wr | input | 1 | Write strobe for the transmit holding register |
| thr_data | input | 8 | Character to transmit |
| thr_empty | output | 1 | Holding register is free |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| fifo_full | input | 1 | Receive FIFO cannot take a character |
| fifo_push | output | 1 | One-cycle push of a received character |
| fifo_data | output | 8 | Received data bits |
| fifo_adtag | output | 1 | Received tag (status bit 5 position) |
| fifo_ferr | output | 1 | Framing error of the pushed character |
| fifo_brk | output | 1 | Break of the pushed character |
| rx_ready | output | 1 | One-cycle wake pulse for the CPU |
| rx_ovr | output | 1 | One-cycle overrun pulse |

## Verification
On the transmit side, the bench sends back-to-back characters in three configurations: 8 bits with a tag and one stop bit, 5 bits untagged with two stop bits, and 7 bits with a tag and two stop bits. The gap between two frames separates one stop bit from two. Changing `cfg_adtag` just after a load shows whether the tag is captured at load time or read live. On the receive side, address-tagged and data-tagged characters are sent with the receiver enabled and disabled, in multidrop and plain mode, which isolates the wake-up filter from the plain enable. A short low glitch, a bad stop bit, a long break followed by a clean character, and characters sent with the FIFO full cover the false-start, framing, break re-arm and overrun paths.

// File: rtl/mdu_pkg.sv
// Shared types and frame helpers for the multidrop UART channel.
// Assumes at most 8 data bits, one optional tag bit and up to two stop bits,
// so a frame never exceeds 12 bit periods.
package mdu_pkg;

    localparam int FRAME_W = 12;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rx_state_t;

    // Number of data bits selected by the 2-bit size field.
    function automatic logic [3:0] data_bits(input logic [1:0] dsel);
        return 4'd5 + {2'b00, dsel};
    endfunction

    // Serial image of one frame, LSB first, padded with idle-high bits.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
                                                       input logic [1:0] dsel,
                                                       input logic md,
                                                       input logic tag);
        logic [FRAME_W-1:0] f;
        int n;
        f = '1;
        f[0] = 1'b0;
        n = 5 + int'(dsel);
        for (int i = 0; i < 8; i++) begin
            if (i < n) f[i+1] = d[i];
        end
        if (md) f[n+1] = tag;
        return f;
    endfunction

    // Frame length in bit periods: start + data + tag + stops.
    function automatic logic [3:0] frame_len(input logic [1:0] dsel,
                                             input logic md,
                                             input logic stop2);
        return data_bits(dsel) + 4'd2 + {3'b000, md} + {3'b000, stop2};
    endfunction

endpackage

// File: rtl/mdu_tx.sv
// Transmitter: a one-entry holding register feeding a shift register.
// The frame image, including the tag bit, is built once when the held
// character is loaded, so later mode changes do not touch it.
// Assumes tick is a one-cycle pulse at OVS times the bit rate.
module mdu_tx import mdu_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_md,
    input  logic       cfg_tag,
    input  logic [1:0] cfg_dsel,
    input  logic       cfg_stop2,
    input  logic       thr_wr,
    input  logic [7:0] thr_data,
    output logic       thr_empty,
    output logic       txd
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic               busy;
    logic [FRAME_W-1:0] sh;
    logic [3:0]         nleft;
    logic [CW-1:0]      tcnt;
    logic [7:0]         hold;
    logic               hfull;

    // Holding register, load into the shifter, and bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sh    <= '1;
            nleft <= '0;
            tcnt  <= '0;
            hold  <= '0;
            hfull <= 1'b0;
        end else begin
            if (!busy && hfull && tick) begin
                sh    <= build_frame(hold, cfg_dsel, cfg_md, cfg_tag);
                nleft <= frame_len(cfg_dsel, cfg_md, cfg_stop2);
                tcnt  <= '0;
                busy  <= 1'b1;
                hfull <= 1'b0;
            end else if (busy && tick) begin
                if (tcnt == LAST) begin
                    tcnt  <= '0;
                    sh    <= {1'b1, sh[FRAME_W-1:1]};
                    nleft <= nleft - 4'd1;
                    if (nleft == 4'd1) busy <= 1'b0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            if (thr_wr) begin
                hold  <= thr_data;
                hfull <= 1'b1;
            end
        end
    end

    assign thr_empty = !hfull;
    assign txd       = busy ? sh[0] : 1'b1;

    // A frame always opens with a low start bit.
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // The line moves only on tick edges.
    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !thr_wr) |=> $stable(txd));

    // The holding register empties only by a load, which needs a tick.
    assert_load_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_empty) |-> $past(tick));

endmodule

// File: rtl/mdu_rx.sv
// Receiver: finds a start bit, validates it at mid-bit, then samples data,
// the optional tag and the first stop bit, each at mid-bit.
// It runs whether or not the channel is enabled; filtering is done later.
// After a frame it waits for the line to be seen high before re-arming.
module mdu_rx import mdu_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       cfg_md,
    input  logic [1:0] cfg_dsel,
    output logic       done,
    output logic [7:0] o_data,
    output logic       o_tag,
    output logic       o_ferr,
    output logic       o_brk
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] SMP  = CW'(OVS / 2 - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [7:0]    dat;
    logic          tag;
    logic          armed;
    logic [3:0]    nb;

    assign nb = data_bits(cfg_dsel);

    // Frame recognition and per-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            dat    <= '0;
            tag    <= 1'b0;
            armed  <= 1'b0;
            done   <= 1'b0;
            o_data <= '0;
            o_tag  <= 1'b0;
            o_ferr <= 1'b0;
            o_brk  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (rxd) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            state <= RX_START;
                            cnt   <= '0;
                            dat   <= '0;
                            tag   <= 1'b0;
                        end
                    end
                    RX_START: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == SMP) begin
                            if (rxd) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_BITS;
                                bidx  <= '0;
                            end
                        end
                    end
                    RX_BITS: begin
                        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                        if (cnt == SMP) begin
                            bidx <= bidx + 4'd1;
                            if (bidx < nb) begin
                                dat[bidx[2:0]] <= rxd;
                            end else if (cfg_md && bidx == nb) begin
                                tag <= rxd;
                            end else begin
                                done   <= 1'b1;
                                o_data <= dat;
                                o_tag  <= tag;
                                o_ferr <= !rxd;
                                o_brk  <= !rxd && dat == 8'd0 && !tag;
                                state  <= RX_IDLE;
                                armed  <= 1'b0;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // One completion pulse per frame.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A high line at the validation tick abandons the start.
    assert_false_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick && cnt == SMP && rxd) |=> state == RX_IDLE);

    // After a frame, a held-low line never starts a new one.
    assert_break_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !armed && !rxd) |=> state == RX_IDLE);

endmodule

// File: rtl/mdu_accept.sv
// Acceptance filter: decides which completed characters reach the FIFO.
// Enabled: all. Disabled: address-tagged characters in multidrop mode and
// breaks. A character that would be pushed into a full FIFO is an overrun.
module mdu_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic tag,
    input  logic brk,
    input  logic rx_en,
    input  logic md,
    input  logic fifo_full,
    output logic push,
    output logic ovr,
    output logic ready
);
    logic keep;

    // Acceptance decision for the completed character.
    always_comb begin
        keep  = done && (rx_en || (md && tag) || brk);
        push  = keep && !fifo_full;
        ovr   = keep && fifo_full;
        ready = push;
    end

    // A disabled multidrop receiver drops data-tagged characters.
    assert_drop_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_en && md && !tag && !brk) |-> !push && !ovr);

    // Never both pushed and overrun.
    assert_push_or_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && ovr));

    // No push without a completed frame.
    assert_push_needs_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> done);

endmodule

// File: rtl/mdrop_uart_chan.sv
// Top of the multidrop UART channel: transmitter, always-on receiver and
// acceptance filter. Multidrop mode is selected by a mode field of 2'b11.
// Assumes tick16 comes from an external baud generator and that the FIFO
// holding received characters sits outside this block.
module mdrop_uart_chan #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [1:0] cfg_pmode,
    input  logic       cfg_adtag,
    input  logic [1:0] cfg_dsel,
    input  logic       cfg_stop2,
    input  logic       rx_en,
    input  logic       thr_wr,
    input  logic [7:0] thr_data,
    output logic       thr_empty,
    output logic       txd,
    input  logic       rxd,
    input  logic       fifo_full,
    output logic       fifo_push,
    output logic [7:0] fifo_data,
    output logic       fifo_adtag,
    output logic       fifo_ferr,
    output logic       fifo_brk,
    output logic       rx_ready,
    output logic       rx_ovr
);
    logic md;
    logic rx_done;

    assign md = (cfg_pmode == 2'b11);

    mdu_tx #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .cfg_md    (md),
        .cfg_tag   (cfg_adtag),
        .cfg_dsel  (cfg_dsel),
        .cfg_stop2 (cfg_stop2),
        .thr_wr    (thr_wr),
        .thr_data  (thr_data),
        .thr_empty (thr_empty),
        .txd       (txd)
    );

    mdu_rx #(.OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rxd      (rxd),
        .cfg_md   (md),
        .cfg_dsel (cfg_dsel),
        .done     (rx_done),
        .o_data   (fifo_data),
        .o_tag    (fifo_adtag),
        .o_ferr   (fifo_ferr),
        .o_brk    (fifo_brk)
    );

    mdu_accept u_accept (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (rx_done),
        .tag       (fifo_adtag),
        .brk       (fifo_brk),
        .rx_en     (rx_en),
        .md        (md),
        .fifo_full (fifo_full),
        .push      (fifo_push),
        .ovr       (rx_ovr),
        .ready     (rx_ready)
    );

endmodule

// File: tb/mdrop_uart_chan_bench.sv
// Directed bench for the multidrop UART channel. Ticks come every 2 clocks,
// so one bit lasts 32 clocks. All inputs change on the falling clock edge.
module mdrop_uart_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BITCLK     = 32;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_pmode = 2'b00;
    logic       cfg_adtag = 1'b0;
    logic [1:0] cfg_dsel = 2'b11;
    logic       cfg_stop2 = 1'b0;
    logic       rx_en = 1'b0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic       thr_empty;
    logic       txd;
    logic       rxd = 1'b1;
    logic       fifo_full = 1'b0;
    logic       fifo_push;
    logic [7:0] fifo_data;
    logic       fifo_adtag;
    logic       fifo_ferr;
    logic       fifo_brk;
    logic       rx_ready;
    logic       rx_ovr;

    int checks = 0;
    int errors = 0;
    int n_push = 0;
    int n_rdy  = 0;
    int n_ovr  = 0;
    logic [7:0] last_data = 8'h00;
    logic       last_tag  = 1'b0;
    logic       last_ferr = 1'b0;
    logic       last_brk  = 1'b0;

    mdrop_uart_chan u_mdrop_uart_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .cfg_pmode  (cfg_pmode),
        .cfg_adtag  (cfg_adtag),
        .cfg_dsel   (cfg_dsel),
        .cfg_stop2  (cfg_stop2),
        .rx_en      (rx_en),
        .thr_wr     (thr_wr),
        .thr_data   (thr_data),
        .thr_empty  (thr_empty),
        .txd        (txd),
        .rxd        (rxd),
        .fifo_full  (fifo_full),
        .fifo_push  (fifo_push),
        .fifo_data  (fifo_data),
        .fifo_adtag (fifo_adtag),
        .fifo_ferr  (fifo_ferr),
        .fifo_brk   (fifo_brk),
        .rx_ready   (rx_ready),
        .rx_ovr     (rx_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick every second clock, changed away from the active edge.
    initial forever begin
        @(negedge clk);
        tick16 = ~tick16;
    end

    // Record what the receive side presents.
    always @(negedge clk) begin
        if (fifo_push) begin
            n_push++;
            last_data = fifo_data;
            last_tag  = fifo_adtag;
            last_ferr = fifo_ferr;
            last_brk  = fifo_brk;
        end
        if (rx_ready) n_rdy++;
        if (rx_ovr)   n_ovr++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] dsel,
                                              input logic md, input logic tag);
        logic [11:0] f;
        int n;
        f = '1;
        f[0] = 1'b0;
        n = 5 + int'(dsel);
        for (int i = 0; i < n; i++) f[i+1] = d[i];
        if (md) f[n+1] = tag;
        return f;
    endfunction

    // Two back-to-back characters; optionally flip the tag right after the
    // first load. Checks both frames, the stop length and the holding flag.
    task automatic tx_pair(input logic [7:0] d1, input logic [7:0] d2, input logic [1:0] dsel,
                           input logic md, input logic tag, input logic stop2, input logic flip);
        logic [11:0] got;
        logic [11:0] e1;
        logic [11:0] e2;
        int len;
        int guard;
        len = 7 + int'(dsel) + int'(md) + int'(stop2);
        cfg_dsel  = dsel;
        cfg_pmode = md ? 2'b11 : 2'b00;
        cfg_adtag = tag;
        cfg_stop2 = stop2;
        e1 = exp_frame(d1, dsel, md, tag);
        e2 = exp_frame(d2, dsel, md, flip ? !tag : tag);
        @(negedge clk);
        thr_data = d1;
        thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0;
        chk("R12 holding busy after write", int'(thr_empty), 0);
        guard = 0;
        while (txd && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk("R12 holding freed at load", int'(thr_empty), 1);
        thr_data = d2;
        thr_wr = 1'b1;
        if (flip) cfg_adtag = !tag;
        @(negedge clk);
        thr_wr = 1'b0;
        repeat (15) @(negedge clk);
        got = '1;
        for (int i = 0; i < len; i++) begin
            got[i] = txd;
            if (i < len - 1) repeat (BITCLK) @(negedge clk);
        end
        for (int i = len; i < 12; i++) got[i] = 1'b1;
        chk("R2 R3 first frame bits", int'(got), int'(e1));
        repeat (15) @(negedge clk);
        chk("R4 last stop bit still high", int'(txd), 1);
        repeat (11) @(negedge clk);
        chk("R4 next start follows stops", int'(txd), 0);
        repeat (8) @(negedge clk);
        got = '1;
        for (int i = 0; i < len; i++) begin
            got[i] = txd;
            if (i < len - 1) repeat (BITCLK) @(negedge clk);
        end
        for (int i = len; i < 12; i++) got[i] = 1'b1;
        chk("R3 second frame bits (tag captured at load)", int'(got), int'(e2));
        repeat (BITCLK * 3) @(negedge clk);
        chk("R4 line idle high", int'(txd), 1);
    endtask

    // Drive one character on rxd; stop_v sets the stop level.
    task automatic rx_send(input logic [7:0] d, input logic [1:0] dsel, input logic md,
                           input logic tag, input logic stop_v);
        int n;
        n = 5 + int'(dsel);
        cfg_dsel  = dsel;
        cfg_pmode = md ? 2'b11 : 2'b00;
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (md) begin
            rxd = tag;
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 3) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (40) @(negedge clk);
        chk("R1 txd idle after reset", int'(txd), 1);
        chk("R1 holding empty after reset", int'(thr_empty), 1);
        chk("R1 no push after reset", n_push, 0);
        chk("R1 no ready after reset", n_rdy, 0);
    endtask

    task automatic t_tx;
        tx_pair(8'hA5, 8'h3C, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        tx_pair(8'h16, 8'h09, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        tx_pair(8'h55, 8'h2A, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_rx_enabled;
        int p0;
        rx_en = 1'b1;
        p0 = n_push;
        rx_send(8'hC3, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R6 enabled data char pushed", n_push - p0, 1);
        chk("R6 data value", int'(last_data), 8'hC3);
        chk("R6 tag 0 stored", int'(last_tag), 0);
        rx_send(8'h7E, 2'b11, 1'b1, 1'b1, 1'b1);
        chk("R6 enabled address pushed", n_push - p0, 2);
        chk("R6 tag 1 stored", int'(last_tag), 1);
        chk("R6 clean frame no ferr", int'(last_ferr), 0);
        rx_send(8'hEB, 2'b01, 1'b0, 1'b0, 1'b1);
        chk("R6 six-bit char upper bits zero", int'(last_data), 8'h2B);
        chk("R6 plain mode tag zero", int'(last_tag), 0);
    endtask

    task automatic t_rx_disabled;
        int p0;
        int r0;
        rx_en = 1'b0;
        p0 = n_push;
        r0 = n_rdy;
        rx_send(8'h11, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R7 disabled data char dropped", n_push - p0, 0);
        chk("R7 no wake for data char", n_rdy - r0, 0);
        rx_send(8'h42, 2'b11, 1'b1, 1'b1, 1'b1);
        chk("R7 disabled address pushed", n_push - p0, 1);
        chk("R7 wake pulse for address", n_rdy - r0, 1);
        chk("R7 address value", int'(last_data), 8'h42);
        chk("R7 address tag", int'(last_tag), 1);
        rx_send(8'h99, 2'b11, 1'b0, 1'b0, 1'b1);
        chk("R8 plain mode disabled dropped", n_push - p0, 1);
    endtask

    task automatic t_framing;
        int p0;
        p0 = n_push;
        rx_en = 1'b1;
        rx_send(8'h81, 2'b11, 1'b1, 1'b0, 1'b0);
        chk("R9 bad stop pushed", n_push - p0, 1);
        chk("R9 ferr set", int'(last_ferr), 1);
        chk("R9 not a break", int'(last_brk), 0);
        rx_en = 1'b0;
        rx_send(8'h24, 2'b11, 1'b1, 1'b1, 1'b0);
        chk("R9 disabled address with bad stop pushed", n_push - p0, 2);
        chk("R9 ferr while disabled", int'(last_ferr), 1);
    endtask

    task automatic t_break;
        int p0;
        p0 = n_push;
        rx_en = 1'b0;
        cfg_pmode = 2'b11;
        cfg_dsel = 2'b11;
        rxd = 1'b0;
        repeat (BITCLK * 14) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 3) @(negedge clk);
        chk("R10 single push for break", n_push - p0, 1);
        chk("R10 brk flag", int'(last_brk), 1);
        chk("R10 ferr with break", int'(last_ferr), 1);
        rx_en = 1'b1;
        rx_send(8'h5A, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R10 receiver re-arms after break", n_push - p0, 2);
        chk("R10 clean char after break", int'(last_data), 8'h5A);
        chk("R10 brk cleared", int'(last_brk), 0);
    endtask

    task automatic t_glitch;
        int p0;
        p0 = n_push;
        rx_en = 1'b1;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 14) @(negedge clk);
        chk("R5 short low pulse ignored", n_push - p0, 0);
    endtask

    task automatic t_overrun;
        int p0;
        int o0;
        p0 = n_push;
        o0 = n_ovr;
        fifo_full = 1'b1;
        rx_en = 1'b1;
        rx_send(8'h33, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R11 no push when full", n_push - p0, 0);
        chk("R11 overrun pulse", n_ovr - o0, 1);
        rx_en = 1'b0;
        rx_send(8'h44, 2'b11, 1'b1, 1'b0, 1'b1);
        chk("R11 discarded char no overrun", n_ovr - o0, 1);
        fifo_full = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx();
        t_rx_enabled();
        t_rx_disabled();
        t_framing();
        t_break();
        t_glitch();
        t_overrun();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule